// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial port. A processor writes one byte into a holding register. The block moves that byte into a frame shift register and sends it on a single output line, least significant bit first, with one start bit and one stop bit. The shift register advances by one bit each time the baud tick input is high. The tick comes from a rate generator outside the block. While one frame is on the line, software can already place the next byte in the holding register, so frames can follow each other with no gap.

Software reaches the block through four byte-wide registers on a small synchronous bus. Three of them set the mode, the interrupt enables and the data. The fourth reports two flags:
- **buffer-empty**: the holding register can take a new byte.
- **line-done**: the last frame has left the line and nothing is waiting.

Setting the enable bit first sends one full frame of ones, so the receiver sees an idle line before the first data frame. A ninth data bit, taken from the mode register, can be sent. A break mode fills the line with zero frames. A single interrupt output combines both flags, each gated by its own enable.

Top module: `ser_tx_dbuf`

## Requirements
- R1: After reset, `tx_out` is 1 and `irq` is 0. Mode and enable registers read 0. The status register reads buffer-empty = 1 (bit 0) and line-done = 1 (bit 1).
- R2: The register map is as follows. Address 0 is the mode register: bit 0 enable, bit 1 break, bit 2 nine-bit mode, bit 3 ninth data bit. Address 1 holds the interrupt enables: bit 0 for buffer-empty, bit 1 for line-done. Address 2 is the read-only status register. Address 3 is the data register. Addresses 0 and 1 read back what was written.
- R3: When the enable bit goes from 0 to 1, the first baud tick after that write starts a frame of all ones (10 bits, or 11 in nine-bit mode). A data start bit appears no earlier than the tick that ends this frame.
- R4: A data frame is sent one bit per tick in this order: a 0 start bit, data bits 0 to 7, then a 1 stop bit. The line is 1 whenever no frame is being sent.
- R5: In nine-bit mode, the value of mode bit 3 at load time is sent after data bit 7 and before the stop bit.
- R6: A data write made while the block is enabled clears buffer-empty. Buffer-empty is set again on the baud tick that moves the byte into the shift register. That is the same tick on which the start bit appears.
- R7: Line-done is set on the tick that ends a frame when nothing is waiting to be sent. It is cleared only by a data write that follows a status read. A data write with no status read before it leaves line-done set.
- R8: `irq` is high exactly when (buffer-empty and its enable) or (line-done and its enable).
- R9: While the break bit is set, the line carries frames of all zeros, stop position included, so a zero run is a whole number of frame lengths. After break is cleared, at least one 1 bit goes out before the next frame.
- R10: Clearing the enable bit lets the current frame finish, and the line then stays 1. Data writes made while disabled change no flag and start no frame.
- R11: `tx_out` changes only in the cycle after a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse, once per bit time |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (a status read arms flag clearing) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| tx_out | output | 1 | Serial line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The bench rebuilds the line by sampling `tx_out` once per tick. It goes after the exact tick on which the first start bit follows the all-ones frame: a design that skipped that frame, or sent the data early, would put the start bit at the wrong index. It checks the exact ticks on which buffer-empty and line-done rise, which would catch a flag set one bit late or at the end of the frame instead of at the load. It also checks that a data write with no status read before it leaves line-done set. Directed cases cover:
- Break: the zero run must be a whole number of frames and be followed by a mark bit. Missing that mark would join the break to the next start bit.
- Disable in mid-frame: a design that cut the frame short would corrupt the last byte.
- Writes while disabled: a design that took them would start a frame on the line.

// File: rtl/ser_tx_dbuf.sv
module ser_tx_dbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          tx_out,
  output logic          irq
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LEN_STD  = CW'(DW + 2);
  localparam logic [CW-1:0] LEN_NINE = CW'(DW + 3);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic          txen, brk, nine, bit8;
  logic          ie_empty, ie_done;
  logic          empty, done, stat_rd;
  logic          pre_pend, brk_tail, busy;
  logic [DW-1:0] dreg;
  logic [FW-1:0] sh;
  logic [CW-1:0] bcnt;

  wire wr_ctrl = bus_sel & bus_wr & (bus_addr == 2'd0);
  wire wr_ien  = bus_sel & bus_wr & (bus_addr == 2'd1);
  wire rd_stat = bus_sel & bus_rd & (bus_addr == 2'd2);
  wire wr_data = bus_sel & bus_wr & (bus_addr == 2'd3);

  wire            slot = baud_tick & (~busy | (bcnt == ONE));
  wire [CW-1:0]   flen = nine ? LEN_NINE : LEN_STD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txen     <= 1'b0;
      brk      <= 1'b0;
      nine     <= 1'b0;
      bit8     <= 1'b0;
      ie_empty <= 1'b0;
      ie_done  <= 1'b0;
      empty    <= 1'b1;
      done     <= 1'b1;
      stat_rd  <= 1'b0;
      pre_pend <= 1'b0;
      brk_tail <= 1'b0;
      busy     <= 1'b0;
      dreg     <= '0;
      sh       <= '1;
      bcnt     <= '0;
    end else begin
      if (wr_ctrl) begin
        txen <= bus_wdata[0];
        brk  <= bus_wdata[1];
        nine <= bus_wdata[2];
        bit8 <= bus_wdata[3];
      end
      if (wr_ien) begin
        ie_empty <= bus_wdata[0];
        ie_done  <= bus_wdata[1];
      end

      if (baud_tick && busy && bcnt != ONE) begin
        sh   <= {1'b1, sh[FW-1:1]};
        bcnt <= bcnt - ONE;
      end

      if (slot) begin
        if (!txen) begin
          busy     <= 1'b0;
          pre_pend <= 1'b0;
          brk_tail <= 1'b0;
          if (busy) done <= 1'b1;
        end else if (pre_pend) begin
          busy     <= 1'b1;
          sh       <= '1;
          bcnt     <= flen;
          pre_pend <= 1'b0;
        end else if (brk) begin
          busy     <= 1'b1;
          sh       <= '0;
          bcnt     <= flen;
          brk_tail <= 1'b1;
        end else if (brk_tail) begin
          busy     <= 1'b1;
          sh       <= '1;
          bcnt     <= ONE;
          brk_tail <= 1'b0;
        end else if (!empty) begin
          busy  <= 1'b1;
          sh    <= {1'b1, nine ? bit8 : 1'b1, dreg, 1'b0};
          bcnt  <= flen;
          empty <= 1'b1;
        end else begin
          busy <= 1'b0;
          if (busy) done <= 1'b1;
        end
      end

      if (wr_ctrl && bus_wdata[0] && !txen) pre_pend <= 1'b1;

      if (rd_stat) stat_rd <= 1'b1;
      if (wr_data && txen) begin
        dreg    <= bus_wdata;
        empty   <= 1'b0;
        stat_rd <= 1'b0;
        if (stat_rd) done <= 1'b0;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {{(DW-4){1'b0}}, bit8, nine, brk, txen};
      2'd1:    bus_rdata = {{(DW-2){1'b0}}, ie_done, ie_empty};
      2'd2:    bus_rdata = {{(DW-2){1'b0}}, done, empty};
      default: bus_rdata = dreg;
    endcase
  end

  assign tx_out = busy ? sh[0] : 1'b1;
  assign irq    = (empty & ie_empty) | (done & ie_done);

endmodule

// File: rtl/ser_tx_dbuf_chk.sv
module ser_tx_dbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       tx_out,
  input logic       txen,
  input logic       empty,
  input logic       done,
  input logic       stat_rd
);
  wire data_wr = bus_sel && bus_wr && (bus_addr == 2'd3);

  a_r11_tx_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(baud_tick) |-> $stable(tx_out));

  a_r6_empty_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(baud_tick));

  a_r7_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(baud_tick));

  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && txen) |=> !empty);

  a_r7_done_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && txen && stat_rd) |=> !done);

  a_r10_disabled_write: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !txen) |=> $stable(empty));
endmodule

bind ser_tx_dbuf ser_tx_dbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .tx_out(tx_out), .txen(txen),
  .empty(empty), .done(done), .stat_rd(stat_rd)
);

// File: tb/sim_ser_tx_dbuf.sv
`timescale 1ns/1ps
module sim_ser_tx_dbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd2;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tx_out, irq;

  ser_tx_dbuf #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_out(tx_out), .irq(irq)
  );

  always #5 clk = ~clk;

  int nchk = 0, nbad = 0;
  bit line [0:4095];
  bit lirq [0:4095];
  bit lpre [0:4095];
  int nl = 0;
  bit prev_irq = 1'b0;
  int tdiv = 0;
  bit finished = 1'b0;

  initial forever begin
    @(negedge clk);
    tdiv = (tdiv == 7) ? 0 : tdiv + 1;
    baud_tick = (tdiv == 7);
  end

  initial forever begin
    bit t;
    @(posedge clk);
    t = baud_tick;
    #2;
    if (t && rst_n && nl < 4096) begin
      line[nl] = tx_out;
      lirq[nl] = irq;
      lpre[nl] = prev_irq;
      nl++;
    end
    prev_irq = irq;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(posedge clk);
    #2;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0;
  endtask

  task automatic wait_ticks(input int n);
    int s = nl;
    while (nl < s + n) @(negedge clk);
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic dec(inout int idx, input bit nine, output logic [7:0] d,
                     output bit b8, output bit stop_ok, output int sidx);
    while (idx < nl && line[idx]) idx++;
    sidx = idx;
    for (int k = 0; k < 8; k++) d[k] = line[idx + 1 + k];
    b8 = nine ? line[idx + 9] : 1'b0;
    stop_ok = line[idx + (nine ? 10 : 9)];
    idx += nine ? 11 : 10;
  endtask

  function automatic bit all_ones(input int a, input int b);
    for (int i = a; i < b; i++) if (!line[i]) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nbad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d;
    logic [7:0] exp_d [0:9];
    bit exp_b [0:9];
    bit b8, sok;
    int e, z, s, idx, sidx, p1, p2, run;
    void'($urandom(32'd2024));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tx_out == 1'b1, "R1 tx idle", tx_out, 1);
    chk(irq == 1'b0, "R1 irq low", irq, 0);
    rd(2'd2, r); chk(r == 8'h03, "R1 status", r, 3);
    rd(2'd0, r); chk(r == 8'h00, "R1 mode reg", r, 0);

    // R2 readback, R8 irq combination
    wr(2'd0, 8'h0C); rd(2'd0, r); chk(r == 8'h0C, "R2 mode readback", r, 8'h0C);
    wr(2'd1, 8'h02); @(negedge clk); chk(irq == 1'b1, "R8 done enable", irq, 1);
    wr(2'd1, 8'h03); rd(2'd1, r); chk(r == 8'h03, "R2 ien readback", r, 3);
    wr(2'd1, 8'h00); @(negedge clk); chk(irq == 1'b0, "R8 both disabled", irq, 0);
    wr(2'd0, 8'h00);

    // R10 writes while disabled
    s = nl;
    wr(2'd3, 8'h12);
    wait_ticks(15);
    chk(all_ones(s, nl), "R10 no frame when disabled", 0, 1);
    rd(2'd2, r); chk(r == 8'h03, "R10 flags unchanged", r, 3);

    // R3 preamble, R4 framing, R6 empty timing
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h01);
    e = nl;
    rd(2'd2, r);
    wr(2'd3, 8'hA5);
    @(negedge clk);
    chk(irq == 1'b0, "R6 write clears empty", irq, 0);
    wait_ticks(25);
    z = e;
    while (z < nl && line[z]) z++;
    chk(z == e + 10, "R3 preamble length", z - e, 10);
    idx = e;
    dec(idx, 1'b0, d, b8, sok, sidx);
    chk(d == 8'hA5, "R4 data bits", d, 8'hA5);
    chk(sok, "R4 stop bit", sok, 1);
    chk(lpre[z] == 1'b0 && lirq[z] == 1'b1, "R6 empty set at load tick",
        {lpre[z], lirq[z]}, 2'b01);

    // R4 random 8-bit stream
    p1 = nl;
    for (int i = 0; i < 5; i++) begin
      exp_d[i] = 8'($urandom());
      wait_irq();
      rd(2'd2, r);
      wr(2'd3, exp_d[i]);
    end
    wr(2'd1, 8'h02);
    wait_irq();
    idx = p1;
    for (int i = 0; i < 5; i++) begin
      dec(idx, 1'b0, d, b8, sok, sidx);
      chk(d == exp_d[i] && sok, "R4 random byte", d, exp_d[i]);
    end

    // R5 nine-bit stream
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h01);
    p2 = nl;
    for (int i = 0; i < 5; i++) begin
      exp_d[i] = 8'($urandom());
      exp_b[i] = 1'($urandom());
      wait_irq();
      wr(2'd0, {4'h0, exp_b[i], 3'b101});
      rd(2'd2, r);
      wr(2'd3, exp_d[i]);
    end
    wr(2'd1, 8'h02);
    wait_irq();
    idx = p2;
    for (int i = 0; i < 5; i++) begin
      dec(idx, 1'b1, d, b8, sok, sidx);
      chk(d == exp_d[i] && sok, "R5 nine-bit data", d, exp_d[i]);
      chk(b8 == exp_b[i], "R5 ninth bit", b8, exp_b[i]);
    end
    wr(2'd0, 8'h01);

    // R7 line-done clearing and timing
    @(negedge clk);
    chk(irq == 1'b1, "R7 done set when idle", irq, 1);
    wr(2'd3, 8'h5A);
    @(negedge clk);
    chk(irq == 1'b1, "R7 write without status read keeps done", irq, 1);
    wait_ticks(25);
    s = nl;
    rd(2'd2, r);
    wr(2'd3, 8'h81);
    @(negedge clk);
    chk(irq == 1'b0, "R7 read then write clears done", irq, 0);
    wait_ticks(20);
    idx = s;
    dec(idx, 1'b0, d, b8, sok, sidx);
    chk(d == 8'h81, "R4 byte after done", d, 8'h81);
    chk(lirq[sidx + 9] == 1'b0 && lirq[sidx + 10] == 1'b1, "R7 done at frame end",
        {lirq[sidx + 9], lirq[sidx + 10]}, 2'b01);

    // R9 break
    wr(2'd1, 8'h00);
    s = nl;
    wr(2'd0, 8'h03);
    wait_ticks(25);
    wr(2'd0, 8'h01);
    rd(2'd2, r);
    wr(2'd3, 8'h3C);
    wait_ticks(40);
    z = s;
    while (z < nl && line[z]) z++;
    run = 0;
    while (z + run < nl && !line[z + run]) run++;
    chk(run >= 10 && run % 10 == 0, "R9 break whole frames", run, 20);
    chk(line[z + run] == 1'b1, "R9 mark after break", line[z + run], 1);
    idx = z + run;
    dec(idx, 1'b0, d, b8, sok, sidx);
    chk(d == 8'h3C && sok, "R9 frame after break", d, 8'h3C);

    // R10 disable mid-frame
    wr(2'd1, 8'h01);
    s = nl;
    rd(2'd2, r);
    wr(2'd3, 8'hC3);
    z = s;
    while (1) begin
      while (z < nl && line[z]) z++;
      if (z < nl) break;
      @(negedge clk);
    end
    wait_ticks(3);
    wr(2'd0, 8'h00);
    wait_ticks(30);
    idx = s;
    dec(idx, 1'b0, d, b8, sok, sidx);
    chk(d == 8'hC3 && sok, "R10 frame completes after disable", d, 8'hC3);
    chk(all_ones(sidx + 10, nl), "R10 line high after disable", 0, 1);
    s = nl;
    wr(2'd3, 8'h77);
    @(negedge clk);
    chk(irq == 1'b1, "R10 disabled write keeps empty", irq, 1);
    wait_ticks(15);
    chk(all_ones(s, nl), "R10 no frame from disabled write", 0, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule